// File: doc/BRIEF.md
# Integer Execute Unit with Condition Codes

This block is the 64-bit integer execute stage of a processor datapath. Each cycle it takes two operands and an operation code and produces a result with no register in the result path. The operations are add, subtract, the two carry-chained versions of each, six bitwise logic operations and six shifts. The shifts come in a 32-bit and a 64-bit family, each with left, logical-right and arithmetic-right forms. The second operand is either the register value presented on `opnd_b` or a sign-extended 13-bit immediate.

The block holds two registered sets of condition flags: one for the low word and one for the whole doubleword. When the caller asks for a flag update on a valid operation, both sets are loaded together at the clock edge. A compare is a subtract that asks for a flag update, with the result ignored by the caller. The carry-chained operations take their carry or borrow from the stored word-level carry flag. This lets software build wide arithmetic out of a chain of operations.

Top module: `int_exec_unit`

## Requirements
- R1: When `use_imm` is 1, operand B is `imm13` sign-extended to 64 bits, and `opnd_b` has no effect. When it is 0, operand B is `opnd_b`.
- R2: Operation codes 0 (add), 1 (add with carry), 2 (subtract) and 3 (subtract with borrow) give A+B, A+B+c, A−B and A−B−c modulo 2^64. Here c is the stored word-flag carry bit.
- R3: Both flag sets load only at a clock edge where `op_valid` and `set_flags` are both 1. In every other cycle both sets hold their value. Reset clears both sets to 0.
- R4: Codes 4 to 9 give A&B, A|B, A^B, A&~B, A|~B and ~(A^B), in that order.
- R5: Codes 10, 11 and 12 shift `A[31:0]` left, logical-right and arithmetic-right by `B[4:0]`. Bits 63:32 are zero for the left and logical forms and copy result bit 31 for the arithmetic form.
- R6: Codes 13, 14 and 15 shift all 64 bits of A left, logical-right and arithmetic-right by `B[5:0]`.
- R7: Each flag output is packed {N,Z,V,C} from bit 3 down to bit 0. For `icc_flags`, N is result bit 31 and Z is set when result bits 31:0 are all zero. For `xcc_flags`, N is result bit 63 and Z is set when the whole result is zero.
- R8: For codes 0 to 3, V marks signed overflow of the 32-bit or 64-bit operation. C is the carry out of bit 31 or bit 63 for add, and a borrow out of that width for subtract.
- R9: A flag update from a logic or shift operation clears V and C in both sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation is valid this cycle |
| set_flags | input | 1 | Load the flag sets from this operation |
| op_code | input | 4 | Operation select, codes 0 to 15 |
| use_imm | input | 1 | Take operand B from the immediate |
| imm13 | input | 13 | Signed immediate for operand B |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Register value for operand B |
| result | output | 64 | Combinational result |
| icc_flags | output | 4 | Stored word flags {N,Z,V,C} |
| xcc_flags | output | 4 | Stored doubleword flags {N,Z,V,C} |

## Verification
The assertions assume that the operands, the operation code and the control inputs are stable and known across each rising edge. They also assume that inputs change only while reset is low or between edges. The bench drives every input on the falling edge and holds it through the next rising edge, so it meets both conditions. Random stimulus covers all sixteen codes and both operand sources. It is mixed with boundary operands: the extreme signed values, all ones and zero. It also uses shift counts whose ignored upper bits are set, so the overflow, borrow and count-masking cases are reached on both flag widths.

// File: rtl/ieu_pkg.sv
package ieu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_ANDN = 4'd7,
    OP_ORN  = 4'd8,
    OP_XNOR = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12,
    OP_SLLX = 4'd13,
    OP_SRLX = 4'd14,
    OP_SRAX = 4'd15
  } ieu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_SHIFT = 2'd2
  } op_class_e;

  function automatic op_class_e op_class(input ieu_op_e op);
    if (op <= OP_SUBC)      return CLS_ARITH;
    else if (op <= OP_XNOR) return CLS_LOGIC;
    else                    return CLS_SHIFT;
  endfunction

endpackage

// File: rtl/ieu_addsub.sv
module ieu_addsub #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              is_sub_i,
  input  logic              chain_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_word_o,
  output logic              c_dbl_o,
  output logic              v_word_o,
  output logic              v_dbl_o
);
  localparam int HI_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [WORD_W:0]   lo_sum;
  logic [HI_W:0]     hi_sum;

  always_comb begin
    b_eff = is_sub_i ? ~b_i : b_i;
    // subtract uses a + ~b + 1; a borrow-in removes the +1
    if (chain_i) cin = is_sub_i ? ~carry_i : carry_i;
    else         cin = is_sub_i;
  end

  // split at the word boundary so the word carry is a real adder tap
  always_comb begin
    lo_sum = {1'b0, a_i[WORD_W-1:0]} + {1'b0, b_eff[WORD_W-1:0]}
           + {{WORD_W{1'b0}}, cin};
    hi_sum = {1'b0, a_i[DATA_W-1:WORD_W]} + {1'b0, b_eff[DATA_W-1:WORD_W]}
           + {{HI_W{1'b0}}, lo_sum[WORD_W]};
  end

  always_comb begin
    sum_o    = {hi_sum[HI_W-1:0], lo_sum[WORD_W-1:0]};
    c_word_o = lo_sum[WORD_W] ^ is_sub_i;
    c_dbl_o  = hi_sum[HI_W] ^ is_sub_i;
    v_word_o = (a_i[WORD_W-1] == b_eff[WORD_W-1]) &&
               (sum_o[WORD_W-1] != a_i[WORD_W-1]);
    v_dbl_o  = (a_i[DATA_W-1] == b_eff[DATA_W-1]) &&
               (sum_o[DATA_W-1] != a_i[DATA_W-1]);
  end

  // R8: a plain add that carries out of the top wraps below operand A
  always_comb begin
    if (!is_sub_i && !chain_i && c_dbl_o)
      a_r8_add_wrap: assert (sum_o < a_i);
  end

endmodule

// File: rtl/ieu_logic.sv
module ieu_logic #(
  parameter int DATA_W = 64
) (
  input  ieu_pkg::ieu_op_e  op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  import ieu_pkg::*;

  logic [DATA_W-1:0] b_eff;
  logic              inv_b;

  always_comb begin
    inv_b = (op_i == OP_ANDN) || (op_i == OP_ORN);
    b_eff = inv_b ? ~b_i : b_i;
    unique case (op_i)
      OP_AND, OP_ANDN: res_o = a_i & b_eff;
      OP_OR,  OP_ORN:  res_o = a_i | b_eff;
      OP_XOR:          res_o = a_i ^ b_eff;
      OP_XNOR:         res_o = ~(a_i ^ b_eff);
      default:         res_o = '0;
    endcase
  end

endmodule

// File: rtl/ieu_shift.sv
module ieu_shift #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  ieu_pkg::ieu_op_e  op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  import ieu_pkg::*;

  localparam int HI_W    = DATA_W - WORD_W;
  localparam int CNT_W_W = $clog2(WORD_W);
  localparam int CNT_D_W = $clog2(DATA_W);

  logic [CNT_W_W-1:0] cnt_w;
  logic [CNT_D_W-1:0] cnt_d;
  logic [WORD_W-1:0]  lo_a;
  logic [WORD_W-1:0]  w_sll, w_srl, w_sra;

  always_comb begin
    cnt_w = b_i[CNT_W_W-1:0];
    cnt_d = b_i[CNT_D_W-1:0];
    lo_a  = a_i[WORD_W-1:0];
    w_sll = lo_a << cnt_w;
    w_srl = lo_a >> cnt_w;
    w_sra = $signed(lo_a) >>> cnt_w;
  end

  always_comb begin
    unique case (op_i)
      OP_SLL:  res_o = {{HI_W{1'b0}}, w_sll};
      OP_SRL:  res_o = {{HI_W{1'b0}}, w_srl};
      OP_SRA:  res_o = {{HI_W{w_sra[WORD_W-1]}}, w_sra};
      OP_SLLX: res_o = a_i << cnt_d;
      OP_SRLX: res_o = a_i >> cnt_d;
      OP_SRAX: res_o = $signed(a_i) >>> cnt_d;
      default: res_o = '0;
    endcase
  end

  // R5: word-wide logical shifts never leave bits above the word
  always_comb begin
    if (op_i == OP_SLL || op_i == OP_SRL)
      a_r5_word_upper_zero: assert (res_o[DATA_W-1:WORD_W] == '0);
  end

endmodule

// File: rtl/ieu_ccreg.sv
module ieu_ccreg (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  input  ieu_pkg::cc_t  icc_d_i,
  input  ieu_pkg::cc_t  xcc_d_i,
  output ieu_pkg::cc_t  icc_q_o,
  output ieu_pkg::cc_t  xcc_q_o
);
  import ieu_pkg::*;

  cc_t icc_q, xcc_q;
  cc_t icc_nxt, xcc_nxt;

  always_comb begin
    icc_nxt = icc_q;
    xcc_nxt = xcc_q;
    if (upd_i) begin
      icc_nxt = icc_d_i;
      xcc_nxt = xcc_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icc_q <= '0;
      xcc_q <= '0;
    end else begin
      icc_q <= icc_nxt;
      xcc_q <= xcc_nxt;
    end
  end

  assign icc_q_o = icc_q;
  assign xcc_q_o = xcc_q;

  // R3: without an update request both sets keep their value
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> ($stable(icc_q) && $stable(xcc_q)));

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              set_flags,
  input  logic [3:0]        op_code,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm13,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        icc_flags,
  output logic [3:0]        xcc_flags
);
  import ieu_pkg::*;

  localparam int EXT_W = DATA_W - IMM_W;

  ieu_op_e           op;
  op_class_e         cls;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] as_res, lg_res, sh_res;
  logic              c_w, c_d, v_w, v_d;
  logic              upd;
  cc_t               icc_d, xcc_d, icc_q, xcc_q;

  always_comb begin
    op    = ieu_op_e'(op_code);
    cls   = op_class(op);
    b_sel = use_imm ? {{EXT_W{imm13[IMM_W-1]}}, imm13} : opnd_b;
    upd   = op_valid && set_flags;
  end

  ieu_addsub #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_addsub (
    .a_i      (opnd_a),
    .b_i      (b_sel),
    .is_sub_i ((op == OP_SUB) || (op == OP_SUBC)),
    .chain_i  ((op == OP_ADDC) || (op == OP_SUBC)),
    .carry_i  (icc_q.c),
    .sum_o    (as_res),
    .c_word_o (c_w),
    .c_dbl_o  (c_d),
    .v_word_o (v_w),
    .v_dbl_o  (v_d)
  );

  ieu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i  (op),
    .a_i   (opnd_a),
    .b_i   (b_sel),
    .res_o (lg_res)
  );

  ieu_shift #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_shift (
    .op_i  (op),
    .a_i   (opnd_a),
    .b_i   (b_sel),
    .res_o (sh_res)
  );

  always_comb begin
    unique case (cls)
      CLS_ARITH: result = as_res;
      CLS_LOGIC: result = lg_res;
      default:   result = sh_res;
    endcase
  end

  // flag candidates: V and C only meaningful for the adder
  always_comb begin
    icc_d.n = result[WORD_W-1];
    icc_d.z = (result[WORD_W-1:0] == '0);
    xcc_d.n = result[DATA_W-1];
    xcc_d.z = (result == '0);
    if (cls == CLS_ARITH) begin
      icc_d.v = v_w;
      icc_d.c = c_w;
      xcc_d.v = v_d;
      xcc_d.c = c_d;
    end else begin
      icc_d.v = 1'b0;
      icc_d.c = 1'b0;
      xcc_d.v = 1'b0;
      xcc_d.c = 1'b0;
    end
  end

  ieu_ccreg u_ccreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (upd),
    .icc_d_i (icc_d),
    .xcc_d_i (xcc_d),
    .icc_q_o (icc_q),
    .xcc_q_o (xcc_q)
  );

  assign icc_flags = icc_q;
  assign xcc_flags = xcc_q;

  // R9: non-arithmetic flag updates leave V and C clear
  a_r9_vc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cls != CLS_ARITH) |=>
      (icc_flags[1:0] == 2'b00 && xcc_flags[1:0] == 2'b00));

  // R7: stored Z and N track the result seen at the update edge
  a_r7_nz_track: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (icc_flags[2] == ($past(result[WORD_W-1:0]) == '0)) &&
            (xcc_flags[2] == ($past(result) == '0)) &&
            (icc_flags[3] == $past(result[WORD_W-1])) &&
            (xcc_flags[3] == $past(result[DATA_W-1])));

  // R1: the immediate path ignores the register operand
  always_comb begin
    if (use_imm && op == OP_OR)
      a_r1_imm_sext: assert (result[DATA_W-1:IMM_W] ==
        (opnd_a[DATA_W-1:IMM_W] | {EXT_W{imm13[IMM_W-1]}}));
  end

endmodule

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, set_flags, use_imm;
  logic [3:0]  op_code;
  logic [12:0] imm13;
  logic [63:0] opnd_a, opnd_b;
  logic [63:0] result;
  logic [3:0]  icc_flags, xcc_flags;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [3:0] m_icc = 4'h0;
  logic [3:0] m_xcc = 4'h0;

  always #4 clk = ~clk;  // 125 MHz

  int_exec_unit i_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .set_flags(set_flags),
    .op_code(op_code), .use_imm(use_imm), .imm13(imm13),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .icc_flags(icc_flags), .xcc_flags(xcc_flags)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired: actual cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // behavioural reference: flag pack {N,Z,V,C}
  function automatic void ref_op(input logic [3:0] op, input logic [63:0] a,
                                 input logic [63:0] b, input logic cin,
                                 output logic [63:0] r, output logic [3:0] fw,
                                 output logic [3:0] fx);
    logic [65:0] ux;
    logic [33:0] uw;
    logic signed [65:0] ex;
    logic signed [33:0] ew;
    int n;
    logic c;
    r = '0; fw = '0; fx = '0;
    c = (op == 4'd1 || op == 4'd3) ? cin : 1'b0;
    if (op <= 4'd1) begin
      ux = {2'b0, a} + {2'b0, b} + {65'b0, c};
      uw = {2'b0, a[31:0]} + {2'b0, b[31:0]} + {33'b0, c};
      r  = ux[63:0];
      ex = $signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b});
      ew = $signed({{2{a[31]}}, a[31:0]}) + $signed({{2{b[31]}}, b[31:0]});
      if (c) begin ex = ex + 1; ew = ew + 1; end
      fx[0] = ux[64];
      fw[0] = uw[32];
      fx[1] = (ex != $signed({{2{r[63]}}, r}));
      fw[1] = (ew != $signed({{2{r[31]}}, r[31:0]}));
    end else if (op <= 4'd3) begin
      ux = {2'b0, a} - {2'b0, b} - {65'b0, c};
      uw = {2'b0, a[31:0]} - {2'b0, b[31:0]} - {33'b0, c};
      r  = ux[63:0];
      ex = $signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b});
      ew = $signed({{2{a[31]}}, a[31:0]}) - $signed({{2{b[31]}}, b[31:0]});
      if (c) begin ex = ex - 1; ew = ew - 1; end
      fx[0] = ux[65];
      fw[0] = uw[33];
      fx[1] = (ex != $signed({{2{r[63]}}, r}));
      fw[1] = (ew != $signed({{2{r[31]}}, r[31:0]}));
    end else begin
      case (op)
        4'd4: r = a & b;
        4'd5: r = a | b;
        4'd6: r = a ^ b;
        4'd7: r = a & ~b;
        4'd8: r = a | ~b;
        4'd9: r = ~(a ^ b);
        4'd10, 4'd11, 4'd12: begin
          n = int'(b[4:0]);
          for (int i = 0; i < 32; i++) begin
            if (op == 4'd10)      r[i] = (i >= n) ? a[i-n] : 1'b0;
            else if (op == 4'd11) r[i] = (i + n < 32) ? a[i+n] : 1'b0;
            else                  r[i] = (i + n < 32) ? a[i+n] : a[31];
          end
          if (op == 4'd12) r[63:32] = {32{r[31]}};
        end
        default: begin
          n = int'(b[5:0]);
          for (int i = 0; i < 64; i++) begin
            if (op == 4'd13)      r[i] = (i >= n) ? a[i-n] : 1'b0;
            else if (op == 4'd14) r[i] = (i + n < 64) ? a[i+n] : 1'b0;
            else                  r[i] = (i + n < 64) ? a[i+n] : a[63];
          end
        end
      endcase
    end
    fw[3] = r[31];
    fw[2] = (r[31:0] == 32'h0);
    fx[3] = r[63];
    fx[2] = (r == 64'h0);
  endfunction

  function automatic string res_tag(input logic [3:0] op);
    if (op <= 4'd3)      return "R2";
    else if (op <= 4'd9) return "R4";
    else if (op <= 4'd12) return "R5";
    else                 return "R6";
  endfunction

  // called on a falling edge; returns on the next falling edge
  task automatic step(input logic v, input logic sf, input logic [3:0] op,
                      input logic ui, input logic [12:0] im,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [63:0] bb, er;
    logic [3:0]  fw, fx;
    op_valid = v; set_flags = sf; op_code = op; use_imm = ui;
    imm13 = im; opnd_a = a; opnd_b = b;
    bb = ui ? {{51{im[12]}}, im} : b;
    ref_op(op, a, bb, m_icc[0], er, fw, fx);
    #1;
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s op %0d result: actual %h expected %h", tag, op, result, er);
    end
    @(posedge clk);
    if (v && sf) begin m_icc = fw; m_xcc = fx; end
    @(negedge clk);
    checks++;
    if (icc_flags !== m_icc || xcc_flags !== m_xcc) begin
      errors++;
      $display("FAIL R3/R7/R8/R9 flags after op %0d: actual icc %b xcc %b expected icc %b xcc %b",
               op, icc_flags, xcc_flags, m_icc, m_xcc);
    end
  endtask

  function automatic logic [63:0] pick64();
    case ($urandom % 8)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h7FFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return {$urandom, 32'h7FFF_FFFF};
      5: return {$urandom, 32'h8000_0000};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; op_valid = 0; set_flags = 0; op_code = 0; use_imm = 0;
    imm13 = 0; opnd_a = 0; opnd_b = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (icc_flags !== 4'h0 || xcc_flags !== 4'h0) begin
      errors++;
      $display("FAIL R3 reset flags: actual %b %b expected 0000 0000", icc_flags, xcc_flags);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 immediate -4096, register operand ignored
    step(1, 0, 4'd0, 1, 13'h1000, 64'h0, 64'h1234_5678_9ABC_DEF0, "R1");
    step(1, 0, 4'd5, 1, 13'h0FFF, 64'h0, 64'hFFFF_0000_0000_0000, "R1");
    // R7 R8 add overflows: word carry + zero, doubleword signed overflow
    step(1, 1, 4'd0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, "R8");
    // R2 add with stored carry
    step(1, 1, 4'd1, 0, 0, 64'h10, 64'h20, "R2");
    // R8 subtract borrow, then subtract with borrow
    step(1, 1, 4'd2, 0, 0, 64'h0, 64'h1, "R8");
    step(1, 1, 4'd3, 0, 0, 64'h5, 64'h2, "R2");
    step(1, 1, 4'd2, 0, 0, 64'h8000_0000_0000_0000, 64'h1, "R8");
    // R3 holds: no update when set_flags or op_valid low
    step(1, 0, 4'd0, 0, 0, 64'h0, 64'h0, "R3");
    step(0, 1, 4'd4, 0, 0, 64'h0, 64'h0, "R3");
    // R4 inverted-operand forms
    step(1, 1, 4'd7, 0, 0, 64'hFF00_FF00_FF00_FF00, 64'h0F0F_0F0F_0F0F_0F0F, "R4");
    step(1, 1, 4'd8, 0, 0, 64'h0, 64'hFFFF_FFFF_0000_0000, "R4");
    step(1, 1, 4'd9, 0, 0, 64'hAAAA, 64'hAAAA, "R4");
    // R9 clear V and C after arithmetic set them
    step(1, 1, 4'd2, 0, 0, 64'h0, 64'h1, "R8");
    step(1, 1, 4'd5, 0, 0, 64'h1, 64'h0, "R9");
    // R5 word shifts: count masked to 5 bits, sign fill
    step(1, 1, 4'd10, 0, 0, 64'hFFFF_FFFF_C000_0001, 64'h21, "R5");
    step(1, 1, 4'd12, 0, 0, 64'h0000_0000_8000_0000, 64'h4, "R5");
    step(1, 1, 4'd11, 0, 0, 64'hFFFF_FFFF_8000_0000, 64'h3F, "R5");
    // R6 doubleword shifts: count masked to 6 bits
    step(1, 1, 4'd14, 0, 0, 64'h8000_0000_0000_0000, 64'h43, "R6");
    step(1, 1, 4'd15, 0, 0, 64'h8000_0000_0000_0000, 64'h3F, "R6");
    step(1, 1, 4'd13, 1, 13'h1FC1, 64'h1, 64'h0, "R6");

    for (int k = 0; k < 4000; k++) begin
      logic [3:0] op;
      op = 4'($urandom % 16);
      step(($urandom % 8) != 0, $urandom % 2, op, ($urandom % 4) == 0,
           13'($urandom), pick64(), pick64(), res_tag(op));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule